// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address by fetching translation descriptors from memory. A programmable table base register locates a 16 KB first-level table. For each walk the block reads one first-level descriptor. That descriptor either maps a whole 1 MB section, points to a coarse (256-entry) or fine (1024-entry) second-level table, or marks the region as a fault. When it points to a second-level table, one more descriptor is read and decoded as a 64 KB large page, a 4 KB small page, a 1 KB tiny page, or a fault.

A completed walk produces the physical address, the 4-bit domain taken from the first-level descriptor, the 2-bit access-permission value that applies to the address, and a page-size code. A fault at either level produces an abort pulse and a flag giving the level instead. The walker talks to memory through a single-outstanding read port: a one-cycle request with a held address, answered later by a one-cycle response. Only one walk runs at a time. Permission checking, caching of translations and data caches are left to neighbouring blocks.

Top module: `ptw_walker`

## Requirements
- R1: After reset `busy`, `walk_done`, `walk_abort` and `mem_req` are all low.
- R2: The first read of a walk goes to `{tb[31:14], va[31:20], 2'b00}`, where `tb` is the table base register; a write on `base_wr` loads `base_wr_data[31:14]` and bits [13:0] are ignored. The first read appears in the cycle after the request is accepted.
- R3: First-level descriptor bits [1:0] select the kind: 00 fault, 01 coarse table, 10 section, 11 fine table. A section gives `pa = {d[31:20], va[19:0]}`, `perm = d[11:10]` and `page_size = 0`. It needs exactly one memory read.
- R4: A coarse descriptor gives a second read at `{d[31:10], va[19:12], 2'b00}`. A fine descriptor gives a second read at `{d[31:12], va[19:10], 2'b00}`.
- R5: Second-level bits [1:0] select the kind: 00 fault, 01 large, 10 small, 11 tiny. A large page gives `pa = {e[31:16], va[15:0]}` and `page_size = 1`. Its permission is the 2-bit field at `e[4+2k +: 2]` with k = `va[15:14]`.
- R6: A small page gives `pa = {e[31:12], va[11:0]}` and `page_size = 2`. Its permission is the field at `e[4+2k +: 2]` with k = `va[11:10]`.
- R7: A tiny page gives `pa = {e[31:10], va[9:0]}`, `perm = e[5:4]` and `page_size = 3`.
- R8: `domain` is bits [8:5] of the first-level descriptor, for sections and for both kinds of second-level walk.
- R9: A first-level fault ends the walk with `walk_abort` and `fault_lvl = 0`, and no second read is made. A second-level fault ends the walk with `walk_abort` and `fault_lvl = 1`.
- R10: `busy` rises in the cycle after a request is accepted and stays high through the one-cycle `walk_done` or `walk_abort` pulse. It is low in the following cycle. Done and abort are never high together. A request raised while `busy` is high is ignored.
- R11: `mem_req` is a one-cycle pulse and is never raised while a read is outstanding or while the walker is idle. `mem_addr` holds steady while a response is awaited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_wr | input | 1 | Load the table base register |
| base_wr_data | input | 32 | New table base; bits [13:0] ignored |
| req_valid | input | 1 | Start a walk (taken only when not busy) |
| req_va | input | 32 | Virtual address to translate |
| busy | output | 1 | Walk in progress |
| mem_req | output | 1 | One-cycle memory read request |
| mem_addr | output | 32 | Descriptor read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Descriptor read data |
| walk_done | output | 1 | One-cycle pulse: translation valid |
| walk_abort | output | 1 | One-cycle pulse: translation fault |
| fault_lvl | output | 1 | Level of the fault: 0 first, 1 second |
| pa | output | 32 | Physical address |
| domain | output | 4 | Domain of the translation |
| perm | output | 2 | Access-permission field for the address |
| page_size | output | 2 | 0 section, 1 large, 2 small, 3 tiny |

## Verification
Walks are run through every descriptor path: section, coarse-to-small, coarse-to-large, fine-to-tiny and fine-to-small. Faults are placed at each level, and so are entries that were never written. Small and large pages are each hit with more than one sub-field selector, which separates a correct permission pick from one stuck on a fixed field. Coarse and fine tables are indexed with addresses whose bits [11:10] are non-zero, which separates the two index widths. The base register is rewritten with junk in its low bits before a walk, response latency is varied, and a second request is raised in the middle of a walk to show it leaves the read sequence and result untouched.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int ADDR_W = 32;
    localparam int DOM_W  = 4;
    localparam int AP_W   = 2;
    localparam int TB_LSB = 14;
    localparam int TB_W   = ADDR_W - TB_LSB;

    typedef enum logic [1:0] {
        L1_FAULT   = 2'b00,
        L1_COARSE  = 2'b01,
        L1_SECTION = 2'b10,
        L1_FINE    = 2'b11
    } l1_kind_e;

    typedef enum logic [1:0] {
        L2_FAULT = 2'b00,
        L2_LARGE = 2'b01,
        L2_SMALL = 2'b10,
        L2_TINY  = 2'b11
    } l2_kind_e;

    typedef enum logic [1:0] {
        SZ_SECTION = 2'd0,
        SZ_LARGE   = 2'd1,
        SZ_SMALL   = 2'd2,
        SZ_TINY    = 2'd3
    } page_size_e;

    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_REQ, ST_L1_WAIT, ST_L2_REQ, ST_L2_WAIT, ST_FINISH
    } walk_state_e;

    typedef struct packed {
        logic [ADDR_W-1:0] pa;
        logic [DOM_W-1:0]  domain;
        logic [AP_W-1:0]   perm;
        page_size_e        size;
    } walk_result_t;

    typedef struct packed {
        l1_kind_e          kind;
        logic [DOM_W-1:0]  domain;
        logic [ADDR_W-1:0] next_addr;
        walk_result_t      sect;
    } l1_info_t;

    // pick one of the four 2-bit permission fields at [5:4],[7:6],[9:8],[11:10]
    function automatic logic [AP_W-1:0] pick_ap(input logic [ADDR_W-1:0] d,
                                                 input logic [1:0] sel);
        logic [AP_W-1:0] r;
        case (sel)
            2'd0:    r = d[5:4];
            2'd1:    r = d[7:6];
            2'd2:    r = d[9:8];
            default: r = d[11:10];
        endcase
        return r;
    endfunction
endpackage

// File: rtl/ptw_l1_decode.sv
module ptw_l1_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [19:0]       va_lo,
    output l1_info_t          info
);
    logic unused_l1;
    assign unused_l1 = ^{desc[9], desc[4:2]};

    always_comb begin
        info.kind        = l1_kind_e'(desc[1:0]);
        info.domain      = desc[8:5];
        info.sect.pa     = {desc[31:20], va_lo};
        info.sect.domain = desc[8:5];
        info.sect.perm   = desc[11:10];
        info.sect.size   = SZ_SECTION;
        if (desc[1:0] == L1_FINE)
            info.next_addr = {desc[31:12], va_lo[19:10], 2'b00};
        else
            info.next_addr = {desc[31:10], va_lo[19:12], 2'b00};
    end
endmodule

// File: rtl/ptw_l2_decode.sv
module ptw_l2_decode
    import ptw_pkg::*;
(
    input  logic [ADDR_W-1:0] desc,
    input  logic [15:0]       va_lo,
    input  logic [DOM_W-1:0]  dom_in,
    output l2_kind_e          kind,
    output walk_result_t      res
);
    logic unused_l2;
    assign unused_l2 = ^desc[3:2];

    always_comb begin
        kind       = l2_kind_e'(desc[1:0]);
        res.domain = dom_in;
        case (desc[1:0])
            L2_LARGE: begin
                res.pa   = {desc[31:16], va_lo[15:0]};
                res.perm = pick_ap(desc, va_lo[15:14]);
                res.size = SZ_LARGE;
            end
            L2_SMALL: begin
                res.pa   = {desc[31:12], va_lo[11:0]};
                res.perm = pick_ap(desc, va_lo[11:10]);
                res.size = SZ_SMALL;
            end
            default: begin
                res.pa   = {desc[31:10], va_lo[9:0]};
                res.perm = desc[5:4];
                res.size = SZ_TINY;
            end
        endcase
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker
    import ptw_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              base_wr,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_va,
    output logic              busy,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              walk_done,
    output logic              walk_abort,
    output logic              fault_lvl,
    output logic [ADDR_W-1:0] pa,
    output logic [DOM_W-1:0]  domain,
    output logic [AP_W-1:0]   perm,
    output logic [1:0]        page_size
);
    walk_state_e       state;
    logic [TB_W-1:0]   tb_q;
    logic [19:0]       va_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DOM_W-1:0]  dom_q;
    walk_result_t      res_q;
    logic              done_q, abort_q, flvl_q;

    l1_info_t     l1_info;
    l2_kind_e     l2_kind;
    walk_result_t l2_res;

    logic unused_top;
    assign unused_top = ^base_wr_data[TB_LSB-1:0];

    ptw_l1_decode u_l1 (.desc(mem_rsp_data), .va_lo(va_q), .info(l1_info));
    ptw_l2_decode u_l2 (.desc(mem_rsp_data), .va_lo(va_q[15:0]), .dom_in(dom_q),
                        .kind(l2_kind), .res(l2_res));

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            tb_q    <= '0;
            va_q    <= '0;
            addr_q  <= '0;
            dom_q   <= '0;
            res_q   <= '0;
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            flvl_q  <= 1'b0;
        end else begin
            done_q  <= 1'b0;
            abort_q <= 1'b0;
            if (base_wr)
                tb_q <= base_wr_data[ADDR_W-1:TB_LSB];
            case (state)
                ST_IDLE: if (req_valid) begin
                    va_q   <= req_va[19:0];
                    addr_q <= {tb_q, req_va[31:20], 2'b00};
                    state  <= ST_L1_REQ;
                end
                ST_L1_REQ: state <= ST_L1_WAIT;
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    case (l1_info.kind)
                        L1_FAULT: begin
                            res_q   <= '0;
                            abort_q <= 1'b1;
                            flvl_q  <= 1'b0;
                            state   <= ST_FINISH;
                        end
                        L1_SECTION: begin
                            res_q  <= l1_info.sect;
                            done_q <= 1'b1;
                            state  <= ST_FINISH;
                        end
                        default: begin
                            addr_q <= l1_info.next_addr;
                            dom_q  <= l1_info.domain;
                            state  <= ST_L2_REQ;
                        end
                    endcase
                end
                ST_L2_REQ: state <= ST_L2_WAIT;
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    if (l2_kind == L2_FAULT) begin
                        res_q   <= '0;
                        abort_q <= 1'b1;
                        flvl_q  <= 1'b1;
                    end else begin
                        res_q  <= l2_res;
                        done_q <= 1'b1;
                    end
                    state <= ST_FINISH;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = (state != ST_IDLE);
    assign mem_req    = (state == ST_L1_REQ) || (state == ST_L2_REQ);
    assign mem_addr   = addr_q;
    assign walk_done  = done_q;
    assign walk_abort = abort_q;
    assign fault_lvl  = flvl_q;
    assign pa         = res_q.pa;
    assign domain     = res_q.domain;
    assign perm       = res_q.perm;
    assign page_size  = res_q.size;
endmodule

// File: rtl/ptw_walker_chk.sv
module ptw_walker_chk (
    input logic        clk,
    input logic        rst,
    input logic        busy,
    input logic        mem_req,
    input logic [31:0] mem_addr,
    input logic [11:0] req_va_hi,
    input logic        walk_done,
    input logic        walk_abort
);
    AST_RESET_QUIET: assert property (@(posedge clk) $past(rst) |-> !busy && !mem_req && !walk_done && !walk_abort); // R1
    AST_FIRST_READ_INDEX: assert property (@(posedge clk) disable iff (rst) $rose(busy) |-> mem_req && mem_addr[13:2] == $past(req_va_hi)); // R2
    AST_PULSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst) !(walk_done && walk_abort)); // R10
    AST_BUSY_AT_PULSE: assert property (@(posedge clk) disable iff (rst) (walk_done || walk_abort) |-> busy); // R10
    AST_IDLE_AFTER_PULSE: assert property (@(posedge clk) disable iff (rst) (walk_done || walk_abort) |=> !busy); // R10
    AST_REQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst) mem_req |=> !mem_req); // R11
    AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst) !busy |-> !mem_req); // R11
    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (rst) (busy && !mem_req && !$rose(busy)) |-> $stable(mem_addr)); // R11
endmodule

bind ptw_walker ptw_walker_chk u_ptw_chk (
    .clk(clk), .rst(rst), .busy(busy), .mem_req(mem_req), .mem_addr(mem_addr),
    .req_va_hi(req_va[31:20]), .walk_done(walk_done), .walk_abort(walk_abort)
);

// File: tb/test_ptw_walker.sv
`timescale 1ns/1ps
module test_ptw_walker;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        base_wr = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic [31:0] req_va = '0;
    logic        busy, mem_req, walk_done, walk_abort, fault_lvl;
    logic [31:0] mem_addr, pa;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic [3:0]  domain;
    logic [1:0]  perm, page_size;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    logic [31:0] mem [logic [31:0]];
    logic [31:0] ref_base = '0;
    logic [31:0] exp_q [$];
    int          rsp_lat = 1;
    int          pend = 0;
    logic [31:0] pend_addr = '0;

    ptw_walker i_ptw_walker (
        .clk(clk), .rst(rst), .base_wr(base_wr), .base_wr_data(base_wr_data),
        .req_valid(req_valid), .req_va(req_va), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .walk_done(walk_done), .walk_abort(walk_abort), .fault_lvl(fault_lvl),
        .pa(pa), .domain(domain), .perm(perm), .page_size(page_size)
    );

    always #5 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [31:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // memory responder: one read outstanding, checked against expected sequence
    always @(negedge clk) begin
        cycles++;
        mem_rsp_valid = 1'b0;
        if (pend > 0) begin
            pend--;
            if (pend == 0) begin
                mem_rsp_valid = 1'b1;
                mem_rsp_data  = rd(pend_addr);
            end
        end
        if (!rst && mem_req) begin
            chk(pend == 0 && !mem_rsp_valid, "R11", "request while read outstanding", 32'(pend), 0);
            if (exp_q.size() == 0) begin
                chk(1'b0, "R9", "unexpected read", mem_addr, 32'hFFFFFFFF);
            end else begin
                logic [31:0] e;
                e = exp_q.pop_front();
                chk(mem_addr == e, "R2 R4", "read address", mem_addr, e);
            end
            pend_addr = mem_addr;
            pend      = rsp_lat;
        end
    end

    always @(negedge clk) begin
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic write_base(input logic [31:0] v);
        base_wr = 1'b1;
        base_wr_data = v;
        @(negedge clk);
        base_wr = 1'b0;
        ref_base = v & 32'hFFFFC000;
    endtask

    task automatic do_walk(input logic [31:0] va, input int lat,
                           input string tag, input bit poke);
        logic [31:0] d1, d2, a1, a2, epa;
        logic [3:0]  edom;
        logic [1:0]  eperm, esize;
        bit          eab, elvl;
        int          cyc;
        a1 = ref_base + (va >> 20) * 4;
        d1 = rd(a1);
        a2 = 0; d2 = 0; epa = 0; eperm = 0; esize = 0; eab = 0; elvl = 0;
        edom = 4'((d1 >> 5) & 15);
        exp_q.push_back(a1);
        if (d1[1:0] == 2'b00) begin
            eab = 1;
        end else if (d1[1:0] == 2'b10) begin
            epa = (d1 & 32'hFFF00000) | (va & 32'h000FFFFF);
            eperm = 2'((d1 >> 10) & 3);
            esize = 0;
        end else begin
            if (d1[1:0] == 2'b01) a2 = (d1 & ~32'h3FF) + ((va >> 12) & 255) * 4;
            else                  a2 = (d1 & ~32'hFFF) + ((va >> 10) & 1023) * 4;
            exp_q.push_back(a2);
            d2 = rd(a2);
            case (d2[1:0])
                2'b00: begin eab = 1; elvl = 1; end
                2'b01: begin
                    epa = (d2 & 32'hFFFF0000) | (va & 32'h0000FFFF);
                    eperm = 2'((d2 >> (4 + 2 * ((va >> 14) & 3))) & 3); esize = 1;
                end
                2'b10: begin
                    epa = (d2 & 32'hFFFFF000) | (va & 32'h00000FFF);
                    eperm = 2'((d2 >> (4 + 2 * ((va >> 10) & 3))) & 3); esize = 2;
                end
                default: begin
                    epa = (d2 & 32'hFFFFFC00) | (va & 32'h000003FF);
                    eperm = 2'((d2 >> 4) & 3); esize = 3;
                end
            endcase
        end
        rsp_lat = lat;
        req_valid = 1'b1;
        req_va = va;
        @(negedge clk);
        req_valid = 1'b0;
        chk(busy == 1'b1, "R10", "busy after accept", 32'(busy), 1);
        cyc = 0;
        while (!(walk_done || walk_abort) && cyc < 200) begin
            if (poke && cyc == 2) begin
                req_valid = 1'b1;
                req_va = va ^ 32'hFFF00000;
            end else begin
                req_valid = 1'b0;
            end
            @(negedge clk);
            cyc++;
        end
        req_valid = 1'b0;
        chk(walk_abort == eab && walk_done == !eab, tag, "done/abort outcome",
            {walk_done, walk_abort}, {!eab, eab});
        chk(busy == 1'b1, "R10", "busy during pulse", 32'(busy), 1);
        if (eab) begin
            chk(fault_lvl == elvl, "R9", "fault level", 32'(fault_lvl), 32'(elvl));
        end else begin
            chk(pa == epa, tag, "physical address", pa, epa);
            chk(perm == eperm, tag, "permission", 32'(perm), 32'(eperm));
            chk(page_size == esize, tag, "page size", 32'(page_size), 32'(esize));
            chk(domain == edom, "R8", "domain", 32'(domain), 32'(edom));
        end
        chk(exp_q.size() == 0, "R9", "reads left unissued", 32'(exp_q.size()), 0);
        exp_q.delete();
        @(negedge clk);
        chk(!busy && !walk_done && !walk_abort, "R10", "idle after pulse",
            {busy, walk_done, walk_abort}, 0);
    endtask

    initial begin
        // section at VA 0x123xxxxx, base 0x00040000
        mem[32'h00040000 + 32'h123 * 4] = 32'hABC00000 | (3 << 10) | (5 << 5) | 2;
        // coarse table at 0x00100400 for VA 0x200xxxxx, domain 9
        mem[32'h00040000 + 32'h200 * 4] = 32'h00100400 | (9 << 5) | 1;
        mem[32'h00100400 + 8'h01 * 4]   = 32'h55555000 | (32'hE4 << 4) | 2;
        mem[32'h00100400 + 8'h3C * 4]   = 32'h77770000 | (32'h1B << 4) | 1;
        mem[32'h00100400 + 8'h34 * 4]   = 32'h77770000 | (32'h1B << 4) | 1;
        // fine table at 0x00203000 for VA 0x300xxxxx, domain 14
        mem[32'h00040000 + 32'h300 * 4] = 32'h00203000 | (14 << 5) | 3;
        mem[32'h00203000 + 10'h015 * 4] = 32'h99999C00 | (2 << 4) | 3;
        mem[32'h00203000 + 10'h01A * 4] = 32'h44444000 | (32'hE4 << 4) | 2;
        // explicit first-level fault with junk bits
        mem[32'h00040000 + 32'h500 * 4] = 32'hFFFFFFFC;
        // section under a second base
        mem[32'h00080000 + 32'h123 * 4] = 32'h0DE00000 | (1 << 10) | (3 << 5) | 2;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        chk(!busy && !walk_done && !walk_abort && !mem_req, "R1", "reset outputs",
            {busy, walk_done, walk_abort, mem_req}, 0);

        write_base(32'h00040000);
        do_walk(32'h12345678, 1, "R3", 0);       // section
        do_walk(32'h20001C00, 2, "R6", 0);       // coarse, small, subpage 3
        do_walk(32'h20001400, 1, "R6", 0);       // coarse, small, subpage 1
        do_walk(32'h2003C123, 3, "R5", 0);       // coarse, large, field 3
        do_walk(32'h20034ABC, 1, "R5", 0);       // coarse, large, field 1
        do_walk(32'h300057FF, 2, "R7", 0);       // fine, tiny
        do_walk(32'h30006BCD, 1, "R4", 0);       // fine, small, subpage 2
        do_walk(32'h40000000, 1, "R9", 0);       // unwritten L1 entry
        do_walk(32'h500ABCDE, 4, "R9", 0);       // explicit L1 fault
        do_walk(32'h20002000, 2, "R9", 0);       // L2 fault in coarse table
        do_walk(32'h2003C000, 7, "R10", 1);      // request during busy ignored
        write_base(32'h00081234);                // low bits dropped
        do_walk(32'h12300001, 1, "R2", 0);       // section via new base
        do_walk(32'h123FFFFF, 5, "R11", 0);      // long latency

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule